// File: doc/BRIEF.md
# Parallel LED String Bit-Slot Waveform Generator

This block drives up to eight single-wire addressable LED strings in lockstep from one output port. Software (or an upstream mover) supplies bytes that are already laid out as bit-planes: bit n of every byte is the next bit for string n. For each byte the block emits one bit slot of fixed length on every line. Each slot has three parts. All enabled lines go high at the start. In the middle part each line carries its own data bit. In the final part all lines are low.

A frame begins with a start pulse that carries a byte count, a channel-enable mask and a requested reset-gap length. The first byte is preloaded before the first slot begins. Each later byte is fetched at the first clock of the low part of the current slot. This keeps fetch latency out of the slot timing. After the last slot every line stays low for the reset gap, and then a one-cycle done pulse is given. If the byte source has nothing ready at a fetch point, the block records an underrun. It then sends one slot that is low on every line, and closes the frame through the reset gap.

Top module: `ledpar_slot_gen`

## Requirements
- R1: Every bit slot lasts exactly SLOT_CLKS (default 20) clocks. Slots follow each other with no idle clock between them.
- R2: In slot clocks 0 to HIGH_END-1 (default 0..5), led_out equals the latched channel mask.
- R3: In slot clocks HIGH_END to LOW_START-1 (default 6..12), led_out[n] equals bit n of the slot's byte ANDed with mask bit n.
- R4: In slot clocks LOW_START to SLOT_CLKS-1 (default 13..19), every line of led_out is 0.
- R5: chan_mask, byte_count and gap_len are sampled only when start is accepted while idle. Later changes to them, and start pulses while busy, have no effect on the running frame.
- R6: A frame with byte_count = N produces exactly N slots and consumes exactly N bytes. With N = 0 the block goes straight to the reset gap.
- R7: in_ready is high only in two cases. The first is while the block waits for the first byte. The second is slot clock LOW_START of a slot that is not the last slot of the frame. A byte is taken when in_ready and in_valid are both high.
- R8: After the last slot, led_out stays 0 and busy stays 1 for max(gap_len, MIN_GAP) clocks (MIN_GAP default 800). Then done is high for exactly one clock, and busy is 0 in that clock.
- R9: If in_valid is low at a fetch point, underrun goes high on the next clock and stays high until the next accepted start. The following slot is 0 on every line for all its clocks, and no further byte is requested. The reset gap then follows.
- R10: Out of reset, and while idle, led_out, busy, done, in_ready and underrun are all 0. While the block waits for the first byte, led_out stays 0. The first slot then shows that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted only while idle) |
| byte_count | input | CNT_W | Number of slots in the frame |
| chan_mask | input | CHANNELS | Per-line enable; a 0 keeps that line low |
| gap_len | input | GAP_W | Requested reset-gap length in clocks |
| in_data | input | CHANNELS | Byte from the source, bit n for line n |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Block takes a byte this clock |
| led_out | output | CHANNELS | Line drive levels |
| busy | output | 1 | Frame in progress, including the reset gap |
| done | output | 1 | One-clock pulse at the end of a frame |
| underrun | output | 1 | Sticky: a fetch point found no byte |

## Verification
The hardest case to reach is the underrun. It needs the source to be ready for the preload and for the early fetch points, and then empty at exactly one later fetch point, in the middle of a running frame. The bench feeds bytes from a memory with a supply limit. A four-byte frame that has only two bytes on hand runs out at the second fetch point. The bench then checks that the all-low slot follows and that no further bytes are requested. A second hard case is a change to the mask, or a start pulse, while a frame is in flight. The bench applies both at the opening clock of a mid-frame slot and checks the lines against the mask latched at the start of the frame.

// File: rtl/ledpar_pkg.sv
package ledpar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SLOT,
    ST_GAP
  } gen_state_e;

  typedef enum logic [1:0] {
    SEG_HIGH,
    SEG_DATA,
    SEG_LOW
  } slot_seg_e;

  // Which part of a bit slot a given slot clock belongs to.
  function automatic slot_seg_e seg_of(int unsigned phase, int unsigned high_end,
                                       int unsigned low_start);
    if (phase < high_end) return SEG_HIGH;
    if (phase < low_start) return SEG_DATA;
    return SEG_LOW;
  endfunction

  // Effective reset-gap length: the request, but never below the floor.
  function automatic int unsigned gap_clocks(int unsigned req, int unsigned floor_clks);
    return (req < floor_clks) ? floor_clks : req;
  endfunction

endpackage

// File: rtl/ledpar_slot_timer.sv
module ledpar_slot_timer #(
  parameter int SLOT_CLKS = 20,
  parameter int LOW_START = 13,
  localparam int PH_W = $clog2(SLOT_CLKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic [PH_W-1:0] phase,
  output logic            fetch_pt,
  output logic            slot_end
);

  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(SLOT_CLKS - 1);
  localparam logic [PH_W-1:0] FETCH_PH = PH_W'(LOW_START);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || phase_q == LAST_PH) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase    = phase_q;
  assign fetch_pt = run && (phase_q == FETCH_PH);
  assign slot_end = run && (phase_q == LAST_PH);

endmodule

// File: rtl/ledpar_gap_timer.sv
module ledpar_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] limit,
  output logic             gap_end
);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || gap_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_end = run && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/ledpar_wave_mux.sv
module ledpar_wave_mux
  import ledpar_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int HIGH_END  = 6,
  parameter int LOW_START = 13,
  parameter int PH_W      = 5
) (
  input  logic                active,
  input  logic                blank,
  input  logic [PH_W-1:0]     phase,
  input  logic [CHANNELS-1:0] data,
  input  logic [CHANNELS-1:0] mask,
  output logic [CHANNELS-1:0] led
);

  slot_seg_e seg;

  always_comb begin
    seg = seg_of(int'(phase), HIGH_END, LOW_START);
    led = '0;
    if (active && !blank) begin
      case (seg)
        SEG_HIGH: led = mask;
        SEG_DATA: led = data & mask;
        default:  led = '0;
      endcase
    end
  end

endmodule

// File: rtl/ledpar_slot_gen.sv
module ledpar_slot_gen
  import ledpar_pkg::*;
#(
  parameter int CHANNELS  = 8,
  parameter int SLOT_CLKS = 20,
  parameter int HIGH_END  = 6,
  parameter int LOW_START = 13,
  parameter int CNT_W     = 16,
  parameter int GAP_W     = 16,
  parameter int MIN_GAP   = 800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    byte_count,
  input  logic [CHANNELS-1:0] chan_mask,
  input  logic [GAP_W-1:0]    gap_len,
  input  logic [CHANNELS-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [CHANNELS-1:0] led_out,
  output logic                busy,
  output logic                done,
  output logic                underrun
);

  localparam int PH_W = $clog2(SLOT_CLKS);

  gen_state_e          state_q;
  logic [CNT_W-1:0]    remain_q;
  logic [CHANNELS-1:0] byte_q;
  logic [CHANNELS-1:0] mask_q;
  logic [GAP_W-1:0]    gap_q;
  logic                zero_slot_q;
  logic                pend_zero_q;
  logic                underrun_q;
  logic                done_q;

  // Named internal events, brought out for the checker.
  logic            slot_active;
  logic            gap_active;
  logic            load_active;
  logic [PH_W-1:0] phase;
  logic            fetch_pt;
  logic            slot_end;
  logic            gap_end;
  logic            more_bytes;
  logic            fetch_req;
  logic            fetch_miss;

  assign slot_active = (state_q == ST_SLOT);
  assign gap_active  = (state_q == ST_GAP);
  assign load_active = (state_q == ST_LOAD);
  assign more_bytes  = (remain_q > CNT_W'(1));
  assign fetch_req   = fetch_pt && more_bytes && !zero_slot_q;
  assign fetch_miss  = fetch_req && !in_valid;

  ledpar_slot_timer #(
    .SLOT_CLKS(SLOT_CLKS),
    .LOW_START(LOW_START)
  ) u_slot_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (slot_active),
    .phase   (phase),
    .fetch_pt(fetch_pt),
    .slot_end(slot_end)
  );

  ledpar_gap_timer #(
    .GAP_W(GAP_W)
  ) u_gap_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (gap_active),
    .limit  (gap_q),
    .gap_end(gap_end)
  );

  ledpar_wave_mux #(
    .CHANNELS (CHANNELS),
    .HIGH_END (HIGH_END),
    .LOW_START(LOW_START),
    .PH_W     (PH_W)
  ) u_wave_mux (
    .active(slot_active),
    .blank (zero_slot_q),
    .phase (phase),
    .data  (byte_q),
    .mask  (mask_q),
    .led   (led_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      remain_q    <= '0;
      byte_q      <= '0;
      mask_q      <= '0;
      gap_q       <= '0;
      zero_slot_q <= 1'b0;
      pend_zero_q <= 1'b0;
      underrun_q  <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mask_q      <= chan_mask;
            gap_q       <= GAP_W'(gap_clocks(int'(gap_len), MIN_GAP));
            remain_q    <= byte_count;
            underrun_q  <= 1'b0;
            zero_slot_q <= 1'b0;
            pend_zero_q <= 1'b0;
            state_q     <= (byte_count == '0) ? ST_GAP : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            byte_q  <= in_data;
            state_q <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (fetch_req && in_valid) byte_q <= in_data;
          if (fetch_miss) begin
            pend_zero_q <= 1'b1;
            underrun_q  <= 1'b1;
          end
          if (slot_end) begin
            if (zero_slot_q || !more_bytes) begin
              state_q <= ST_GAP;
            end else begin
              remain_q    <= remain_q - 1'b1;
              zero_slot_q <= pend_zero_q;
              pend_zero_q <= 1'b0;
            end
          end
        end
        default: begin
          if (gap_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign in_ready = load_active || fetch_req;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign underrun = underrun_q;

endmodule

// File: rtl/ledpar_slot_gen_chk.sv
module ledpar_slot_gen_chk #(
  parameter int CHANNELS  = 8,
  parameter int SLOT_CLKS = 20,
  parameter int HIGH_END  = 6,
  parameter int LOW_START = 13,
  parameter int PH_W      = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                underrun,
  input logic                in_ready,
  input logic [CHANNELS-1:0] led_out,
  input logic                slot_active,
  input logic                gap_active,
  input logic                load_active,
  input logic [PH_W-1:0]     phase,
  input logic [CHANNELS-1:0] mask_q,
  input logic                zero_slot_q
);

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && phase == PH_W'(SLOT_CLKS - 1)) |=> (phase == '0)); // R1

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && phase != PH_W'(SLOT_CLKS - 1)) |=> (slot_active && phase == $past(phase) + 1'b1)); // R1

  AST_HIGH_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && !zero_slot_q && phase < PH_W'(HIGH_END)) |-> (led_out == mask_q)); // R2

  AST_LOW_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && phase >= PH_W'(LOW_START)) |-> (led_out == '0)); // R4

  AST_MASKED_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((led_out & ~mask_q) == '0)); // R5

  AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (load_active || (slot_active && phase == PH_W'(LOW_START)))); // R7

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> (led_out == '0 && busy)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(start && !busy)) |=> underrun); // R9

  AST_ZERO_SLOT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && zero_slot_q) |-> (led_out == '0 && !in_ready)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || load_active) |-> (led_out == '0)); // R10

endmodule

bind ledpar_slot_gen ledpar_slot_gen_chk #(
  .CHANNELS (CHANNELS),
  .SLOT_CLKS(SLOT_CLKS),
  .HIGH_END (HIGH_END),
  .LOW_START(LOW_START),
  .PH_W     (PH_W)
) u_ledpar_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .underrun   (underrun),
  .in_ready   (in_ready),
  .led_out    (led_out),
  .slot_active(slot_active),
  .gap_active (gap_active),
  .load_active(load_active),
  .phase      (phase),
  .mask_q     (mask_q),
  .zero_slot_q(zero_slot_q)
);

// File: tb/test_ledpar_slot_gen.sv
`timescale 1ns/1ps
module test_ledpar_slot_gen;

  localparam int CH    = 8;
  localparam int SLOTN = 20;
  localparam int HEND  = 6;
  localparam int LSTRT = 13;
  localparam int MINGP = 800;

  // {byte, expected data part with mask FF, expected data part with mask 5A}
  localparam logic [23:0] VEC [8] = '{
    {8'hA5, 8'hA5, 8'h00},
    {8'h3C, 8'h3C, 8'h18},
    {8'hFF, 8'hFF, 8'h5A},
    {8'h00, 8'h00, 8'h00},
    {8'h81, 8'h81, 8'h00},
    {8'h7E, 8'h7E, 8'h5A},
    {8'h01, 8'h01, 8'h00},
    {8'h80, 8'h80, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   byte_count = '0;
  logic [CH-1:0] chan_mask = '0;
  logic [15:0]   gap_len = '0;
  logic [CH-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CH-1:0] led_out;
  logic          busy, done, underrun;

  int n_chk  = 0;
  int n_fail = 0;
  int feed_idx = 0;
  int feed_limit = 0;
  logic [CH-1:0] feed_mem [16];
  logic [CH-1:0] exp_mem  [16];

  always #2 clk = ~clk;

  ledpar_slot_gen i_ledpar_slot_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .chan_mask(chan_mask), .gap_len(gap_len), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .led_out(led_out),
    .busy(busy), .done(done), .underrun(underrun)
  );

  // Byte source: advance after each accepted byte.
  initial forever begin
    @(negedge clk);
    if (in_ready && in_valid) begin
      @(posedge clk);
      #1;
      feed_idx++;
      in_valid = (feed_idx < feed_limit);
      in_data  = feed_mem[feed_idx % 16];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // n slots requested; supply bytes available; zero_at = index of all-low slot or -1.
  task automatic run_frame(int n, logic [CH-1:0] mask, int gapreq, int supply,
                           int zero_at, int pre_wait, bit disturb);
    int slots_out;
    int g_eff;
    int g_bad;
    logic [CH-1:0] e;
    string tag;
    slots_out = (zero_at >= 0) ? zero_at + 1 : n;
    g_eff     = (gapreq < MINGP) ? MINGP : gapreq;
    feed_idx   = 0;
    feed_limit = (pre_wait > 0) ? 0 : supply;
    in_data    = feed_mem[0];
    in_valid   = (feed_limit > 0);
    @(negedge clk);
    chan_mask = mask; byte_count = 16'(n); gap_len = 16'(gapreq); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n > 0) begin
      for (int w = 0; w < pre_wait; w++) begin
        chk("R10 wait lines low", {23'd0, in_ready, led_out}, {23'd0, 1'b1, 8'h00});
        @(negedge clk);
      end
      if (pre_wait > 0) begin
        feed_limit = supply;
        in_valid = 1'b1;
      end
      chk("R7 preload ready", 32'(in_ready), 32'd1);
      @(negedge clk);
      for (int s = 0; s < slots_out; s++) begin
        for (int p = 0; p < SLOTN; p++) begin
          if (s == zero_at) begin e = '0; tag = "R9 zero slot"; end
          else if (p < HEND) begin e = mask; tag = "R2 high part"; end
          else if (p < LSTRT) begin e = exp_mem[s] & mask; tag = "R3 data part"; end
          else begin e = '0; tag = "R4 low part"; end
          chk(tag, 32'(led_out), 32'(e));
          if (p == LSTRT)
            chk("R7 fetch ready", 32'(in_ready), 32'((s < n - 1) && (s != zero_at)));
          if (p == SLOTN - 1) chk("R1 busy at slot end", 32'(busy), 32'd1);
          if (disturb && s == 1 && p == 0) begin chan_mask = 8'h00; start = 1'b1; byte_count = 16'd1; end
          if (disturb && s == 1 && p == 1) start = 1'b0;
          @(negedge clk);
        end
      end
    end
    chk("R9 underrun flag", 32'(underrun), 32'(zero_at >= 0));
    chk("R6 bytes consumed", 32'(feed_idx), 32'((zero_at >= 0) ? supply : n));
    g_bad = 0;
    for (int g = 0; g < g_eff; g++) begin
      if (led_out !== '0 || busy !== 1'b1 || done !== 1'b0) g_bad++;
      @(negedge clk);
    end
    chk("R8 gap low and busy", 32'(g_bad), 32'd0);
    chk("R8 done pulse", {30'd0, done, busy}, {30'd0, 1'b1, 1'b0});
    @(negedge clk);
    chk("R8 done single", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {27'd0, led_out == '0, busy, done, in_ready, underrun}, {27'd0, 5'b10000});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle outputs", {27'd0, led_out == '0, busy, done, in_ready, underrun}, {27'd0, 5'b10000});

    // Table-driven frames: all lanes, then a sparse mask with mid-frame disturbance (R5).
    for (int i = 0; i < 8; i++) begin
      feed_mem[i] = VEC[i][23:16];
      exp_mem[i]  = VEC[i][15:8];
    end
    run_frame(8, 8'hFF, 5, 8, -1, 0, 1'b0);
    for (int i = 0; i < 8; i++) exp_mem[i] = VEC[i][7:0];
    run_frame(8, 8'h5A, 900, 8, -1, 0, 1'b1);

    // R6: empty frame goes straight to the reset gap.
    run_frame(0, 8'hFF, 10, 0, -1, 0, 1'b0);

    // R9: source runs dry at the second fetch point of a four-byte frame.
    feed_mem[0] = 8'h55; feed_mem[1] = 8'hAA; feed_mem[2] = 8'hFF;
    exp_mem[0]  = 8'h55; exp_mem[1]  = 8'hAA;
    run_frame(4, 8'hFF, 5, 2, 2, 0, 1'b0);

    // R10: first byte arrives late; single slot with a partial mask.
    feed_mem[0] = 8'hC3; exp_mem[0] = 8'hC3;
    run_frame(1, 8'h0F, 5, 1, -1, 5, 1'b0);
    chk("R9 underrun cleared by start", 32'(underrun), 32'd0);
    summary();
  end

endmodule